// File: doc/BRIEF.md
# Programmable Watchdog Timer Register Block

The block is a countdown watchdog that sits behind a 32-byte register window on a simple synchronous bus (strobe, write enable, byte address, 16-bit data, two byte enables). A prescaler divides the core clock into a coarse tick, and the tick decrements a 10-bit counter. Software programs the initial count, restarts the countdown by writing the reload register, and can freeze counting with a halt bit. In the target system one tick is 0.6 s, so `TICK_CLKS` is set to the number of core clocks in that time. A simulation can use a short tick instead.

When the count is zero and a tick arrives, the counter expires and restarts from the programmed initial value. The first expiry sets a timeout flag. If a second expiry arrives while that flag is still set, the block records it and pulses a one-cycle reset request. A no-reboot mask suppresses that pulse. The mask is the OR of an input pin and a register bit. Status flags are cleared by writing ones to them.

Register map (byte offsets, 16-bit registers):
- 0x00: reload / live count.
- 0x04: status A. Bit 0 is the first timeout.
- 0x06: status B. Bit 0 is the second timeout. Bit 1 records that a reset pulse was issued.
- 0x08: control. Bit 11 is the halt bit. The other bits are plain storage.
- 0x0A: mask. Bit 0 is the no-reboot bit.
- 0x12: initial value. Bits 9:0 are the count field. Bits 15:10 are storage.

Top module: `wdt_regblock`

## Requirements
- R1: After reset, the live count and the initial-value field both equal `DEF_INIT`, control reads 0x0800 (halted), both status registers read 0, and `tmo_o` and `wdt_rst_o` are low.
- R2: While not halted, the counter steps down by one every `TICK_CLKS` clocks, measured from the last reload or release of halt. A tick that finds the count at 0 instead restores the initial value.
- R3: A write of any data to offset 0x00 loads the counter from the initial-value field and restarts the prescaler. A read of 0x00 returns the live count in bits 9:0, with bits 15:10 zero.
- R4: A write to 0x12 whose resulting bits 9:0 are below 4 leaves the count field unchanged. Bits 15:10 of 0x12 always take the written bytes.
- R5: A write updates only the bytes whose byte enable is set (be[0] = bits 7:0, be[1] = bits 15:8). The check against 4 applies to the merged field.
- R6: When control bit 11 is 1, the live count does not change except through a reload. The bit reads back as written.
- R7: The first expiry sets status A bit 0, and `tmo_o` follows it. No reset pulse is issued.
- R8: An expiry while status A bit 0 is set does three things: it sets status B bit 0, it drives `wdt_rst_o` high for exactly one cycle, and in the next cycle it sets status B bit 1.
- R9: While `noreboot_i` or mask register bit 0 is 1, `wdt_rst_o` stays low and status B bit 1 stays clear. Status B bit 0 is still set on a second expiry.
- R10: Writing a 1 to a status bit (with be[0] set) clears it. Writing 0 leaves it unchanged.
- R11: Offsets not listed in the map, including odd offsets, read as 0. Writes to them change no state and do not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window |
| bus_be | input | 2 | Byte enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while a read is strobed |
| noreboot_i | input | 1 | External no-reboot mask |
| tmo_o | output | 1 | First-timeout status |
| wdt_rst_o | output | 1 | One-cycle system reset request |

## Verification
The countdown is swept over every initial value from 4 to 7 with a four-clock tick. In each run the live count is read every cycle through two full expiries, and each sample is compared with the arithmetic value V − ((cycles / TICK_CLKS) mod (V+1)). This separates an off-by-one in the tick spacing, in the zero-count handling and in the reload. The same runs pin the exact cycle of the first-timeout flag and of the reset pulse. A second pass repeats the double expiry with the mask taken once from the pin and once from the register, to show that the pulse is suppressed while the flag is still recorded. Byte-enable writes to the initial-value register exercise merges that land above and below the threshold of 4. Accesses to unmapped and odd offsets show that they have no effect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW      = 16;
  localparam int AW      = 5;
  localparam int CW      = 10;
  localparam int BW      = DW / 8;
  localparam int HALT_BIT = 11;
  localparam logic [CW-1:0] MIN_INIT = CW'(4);

  localparam logic [AW-1:0] OFS_RELOAD = 5'h00;
  localparam logic [AW-1:0] OFS_STSA   = 5'h04;
  localparam logic [AW-1:0] OFS_STSB   = 5'h06;
  localparam logic [AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [AW-1:0] OFS_MASK   = 5'h0A;
  localparam logic [AW-1:0] OFS_INIT   = 5'h12;

  function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] nxt,
                                             input logic [BW-1:0] be);
    logic [DW-1:0] res;
    for (int b = 0; b < BW; b++) begin
      res[b*8 +: 8] = be[b] ? nxt[b*8 +: 8] : cur[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int TICK_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick = !clr && (pre_q == LAST);

  always_comb begin
    if (clr || tick) pre_d = '0;
    else             pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  generate
    if (TICK_CLKS > 1) begin : g_gap
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int DEF_INIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic          reload,
  input  logic [CW-1:0] init_val,
  input  logic          first_i,
  input  logic          mask_i,
  output logic [CW-1:0] count,
  output logic          expire,
  output logic          rst_req
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  assign expire  = tick && !halt && (cnt_q == '0);
  assign count   = cnt_q;
  assign rst_req = rst_q;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)                cnt_d = init_val;
    else if (expire)           cnt_d = init_val;
    else if (tick && !halt)    cnt_d = cnt_q - CW'(1);
    rst_d = expire && first_i && !mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(DEF_INIT);
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(reload)) |-> $stable(cnt_q));
  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  p_rst_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !$past(mask_i));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
#(
  parameter int DEF_INIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] count,
  input  logic          expire,
  input  logic          rst_seen,
  output logic          halt,
  output logic          mask_bit,
  output logic          reload,
  output logic [CW-1:0] init_val,
  output logic          first_flag
);
  localparam int HW = DW - CW;

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          mask_q, mask_d;
  logic [HW-1:0] ihi_q, ihi_d;
  logic [CW-1:0] ifld_q, ifld_d;
  logic          first_q, first_d;
  logic          second_q, second_d;
  logic          rstd_q, rstd_d;
  logic          wr, rd;
  logic [DW-1:0] init_mrg;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;
  assign init_mrg = be_merge({ihi_q, ifld_q}, bus_wdata, bus_be);

  always_comb begin
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    ihi_d    = ihi_q;
    ifld_d   = ifld_q;
    first_d  = first_q;
    second_d = second_q;
    rstd_d   = rstd_q;
    reload   = wr && (bus_addr == OFS_RELOAD);
    if (wr && bus_addr == OFS_CTRL) ctrl_d = be_merge(ctrl_q, bus_wdata, bus_be);
    if (wr && bus_addr == OFS_MASK && bus_be[0]) mask_d = bus_wdata[0];
    if (wr && bus_addr == OFS_INIT) begin
      ihi_d = init_mrg[DW-1:CW];
      if (init_mrg[CW-1:0] >= MIN_INIT) ifld_d = init_mrg[CW-1:0];
    end
    if (wr && bus_addr == OFS_STSA && bus_be[0] && bus_wdata[0]) first_d = 1'b0;
    if (wr && bus_addr == OFS_STSB && bus_be[0]) begin
      if (bus_wdata[0]) second_d = 1'b0;
      if (bus_wdata[1]) rstd_d   = 1'b0;
    end
    if (expire && !first_q) first_d  = 1'b1;
    if (expire && first_q)  second_d = 1'b1;
    if (rst_seen)           rstd_d   = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_RELOAD: bus_rdata = {{HW{1'b0}}, count};
        OFS_STSA:   bus_rdata = {{(DW-1){1'b0}}, first_q};
        OFS_STSB:   bus_rdata = {{(DW-2){1'b0}}, rstd_q, second_q};
        OFS_CTRL:   bus_rdata = ctrl_q;
        OFS_MASK:   bus_rdata = {{(DW-1){1'b0}}, mask_q};
        OFS_INIT:   bus_rdata = {ihi_q, ifld_q};
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= DW'(1) << HALT_BIT;
      mask_q   <= 1'b0;
      ihi_q    <= '0;
      ifld_q   <= CW'(DEF_INIT);
      first_q  <= 1'b0;
      second_q <= 1'b0;
      rstd_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
      ihi_q    <= ihi_d;
      ifld_q   <= ifld_d;
      first_q  <= first_d;
      second_q <= second_d;
      rstd_q   <= rstd_d;
    end
  end

  assign halt       = ctrl_q[HALT_BIT];
  assign mask_bit   = mask_q;
  assign init_val   = ifld_q;
  assign first_flag = first_q;

  p_init_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ifld_q >= MIN_INIT);
  p_second_after_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_q) |-> $past(first_q));
endmodule

// File: rtl/wdt_regblock.sv
module wdt_regblock
  import wdt_pkg::*;
#(
  parameter int TICK_CLKS = 15_000_000,
  parameter int DEF_INIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          noreboot_i,
  output logic          tmo_o,
  output logic          wdt_rst_o
);
  logic          tick, halt, mask_bit, reload, expire, first_flag;
  logic [CW-1:0] init_val, count;

  wdt_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(halt || reload), .tick(tick)
  );

  wdt_count #(.DEF_INIT(DEF_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .reload(reload),
    .init_val(init_val), .first_i(first_flag), .mask_i(noreboot_i || mask_bit),
    .count(count), .expire(expire), .rst_req(wdt_rst_o)
  );

  wdt_csr #(.DEF_INIT(DEF_INIT)) u_csr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .count(count), .expire(expire),
    .rst_seen(wdt_rst_o), .halt(halt), .mask_bit(mask_bit), .reload(reload),
    .init_val(init_val), .first_flag(first_flag)
  );

  assign tmo_o = first_flag;
endmodule

// File: tb/wdt_regblock_tb_top.sv
module wdt_regblock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_N   = 4;
  localparam int TB_DEF = 6;

  logic        clk, rst_n, bus_sel, bus_we, noreboot_i, tmo_o, wdt_rst_o;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  wdt_regblock #(.TICK_CLKS(TB_N), .DEF_INIT(TB_DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .noreboot_i(noreboot_i), .tmo_o(tmo_o),
    .wdt_rst_o(wdt_rst_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = 2'b11;
    #1 d = bus_rdata;
    bus_sel = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2;
    int per;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; noreboot_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'h00, d); chk("R1 count", d, 16'(TB_DEF));
    rd(5'h08, d); chk("R1 ctrl", d, 16'h0800);
    rd(5'h04, d); chk("R1 stsA", d, 16'h0000);
    rd(5'h06, d); chk("R1 stsB", d, 16'h0000);
    rd(5'h12, d); chk("R1 init", d, 16'(TB_DEF));
    chk("R1 tmo", {15'b0, tmo_o}, 16'h0);
    chk("R1 rst", {15'b0, wdt_rst_o}, 16'h0);

    // R6 halted after reset
    repeat (20) @(negedge clk);
    rd(5'h00, d); chk("R6 frozen", d, 16'(TB_DEF));

    // R4 threshold and upper bits
    wr(5'h12, 2'b11, 16'h0002); rd(5'h12, d); chk("R4 below 4", d, 16'(TB_DEF));
    wr(5'h12, 2'b11, 16'hFC03); rd(5'h12, d); chk("R4 upper kept", d, 16'hFC00 | 16'(TB_DEF));
    wr(5'h12, 2'b11, 16'h0005); rd(5'h12, d); chk("R4 legal", d, 16'h0005);

    // R5 byte enables
    wr(5'h12, 2'b10, 16'h0100); rd(5'h12, d); chk("R5 hi byte", d, 16'h0105);
    wr(5'h12, 2'b01, 16'h00FF); rd(5'h12, d); chk("R5 lo byte", d, 16'h01FF);
    wr(5'h12, 2'b01, 16'h0002); rd(5'h12, d); chk("R5 merged legal", d, 16'h0102);
    wr(5'h12, 2'b10, 16'h0000); rd(5'h12, d); chk("R5 merged below 4", d, 16'h0102);
    wr(5'h08, 2'b01, 16'h00AB); rd(5'h08, d); chk("R5 ctrl lo", d, 16'h08AB);
    wr(5'h08, 2'b11, 16'h0800); rd(5'h08, d); chk("R6 halt readback", d, 16'h0800);

    // R2 R3 R7 R8 R10 sweep over initial values
    for (int v = 4; v <= 7; v++) begin
      per = (v + 1) * TB_N;
      wr(5'h12, 2'b11, 16'(v));
      wr(5'h08, 2'b11, 16'h0000);
      wr(5'h00, 2'b11, 16'h5A5A);
      for (int j = 0; j <= 2 * per + 2; j++) begin
        rd(5'h00, d);
        chk("R2 count", d, 16'(v - ((j / TB_N) % (v + 1))));
        chk("R7 tmo", {15'b0, tmo_o}, 16'(j >= per));
        chk("R8 rst pulse", {15'b0, wdt_rst_o}, 16'(j == 2 * per));
        @(negedge clk);
      end
      wr(5'h08, 2'b11, 16'h0800);
      rd(5'h00, d); repeat (10) @(negedge clk); rd(5'h00, d2);
      chk("R6 halt stable", d2, d);
      rd(5'h06, d); chk("R8 stsB", d, 16'h0003);
      wr(5'h06, 2'b11, 16'h0000); rd(5'h06, d); chk("R10 zero write", d, 16'h0003);
      wr(5'h06, 2'b11, 16'h0003); rd(5'h06, d); chk("R10 clear B", d, 16'h0000);
      wr(5'h04, 2'b11, 16'h0001); rd(5'h04, d); chk("R10 clear A", d, 16'h0000);
      chk("R10 tmo low", {15'b0, tmo_o}, 16'h0);
    end

    // R9 masking by pin (m=0) and register (m=1)
    for (int m = 0; m < 2; m++) begin
      per = 5 * TB_N;
      wr(5'h12, 2'b11, 16'h0004);
      if (m == 0) noreboot_i = 1;
      else begin
        wr(5'h0A, 2'b11, 16'h0001);
        rd(5'h0A, d); chk("R9 mask readback", d, 16'h0001);
      end
      wr(5'h08, 2'b11, 16'h0000);
      wr(5'h00, 2'b11, 16'h0000);
      for (int j = 0; j <= 2 * per + 2; j++) begin
        chk("R9 rst masked", {15'b0, wdt_rst_o}, 16'h0);
        @(negedge clk);
      end
      wr(5'h08, 2'b11, 16'h0800);
      rd(5'h06, d); chk("R9 stsB", d, 16'h0001);
      chk("R9 tmo", {15'b0, tmo_o}, 16'h1);
      wr(5'h06, 2'b01, 16'h0003);
      wr(5'h04, 2'b01, 16'h0001);
      noreboot_i = 0;
      wr(5'h0A, 2'b11, 16'h0000);
    end

    // R3 reload while halted; R11 unmapped offsets
    wr(5'h12, 2'b11, 16'h0009);
    wr(5'h00, 2'b01, 16'h0000);
    rd(5'h00, d); chk("R3 reload halted", d, 16'h0009);
    wr(5'h12, 2'b11, 16'h000C);
    rd(5'h00, d); chk("R3 no reload on init write", d, 16'h0009);
    wr(5'h01, 2'b11, 16'h1234);
    rd(5'h00, d); chk("R11 odd no reload", d, 16'h0009);
    wr(5'h13, 2'b11, 16'h0020);
    rd(5'h12, d); chk("R11 init untouched", d, 16'h000C);
    wr(5'h0C, 2'b11, 16'hFFFF);
    rd(5'h0C, d); chk("R11 unmapped read", d, 16'h0000);
    rd(5'h1E, d); chk("R11 top read", d, 16'h0000);
    rd(5'h03, d); chk("R11 odd read", d, 16'h0000);
    rd(5'h08, d); chk("R11 ctrl untouched", d, 16'h0800);
    wr(5'h00, 2'b11, 16'hFFFF);
    rd(5'h00, d); chk("R3 reload", d, 16'h000C);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule